// File: doc/BRIEF.md
# Coarse-Grained Thread Switch Controller

This block decides which of four hardware thread contexts owns a single-issue, in-order pipeline. The owning thread runs until the pipeline reports a long-latency stall for it (a cache miss, for example). The controller then parks that thread, picks a successor among the threads that are ready, has the pipeline discard the outgoing thread's younger instructions, and points fetch at the successor's saved program counter. The active thread number it drives selects the register-file bank. A short stall never moves ownership.

Each context sits in one of four states: idle (never started), ready, running, or waiting on a miss. A waiting thread returns to ready only on its own miss-complete pulse. The pipeline latches are shared, not copied per thread, so every switch away from a thread costs a flush. The pipeline supplies the PC of the oldest discarded instruction, and that PC is kept as the resume point of the outgoing thread.

A programmable starvation limit bounds how long one thread may keep the pipeline without stalling. When the limit runs out and another thread is ready, the running thread is preempted and sent back to ready with the lowest priority for the next pick. If nobody else is ready, it keeps running and the limit restarts. When a stall leaves no thread ready, the controller issues bubbles and holds the thread number until a thread becomes ready.

Top module: `cgmt_switch_ctrl`

## Requirements
- R1: While reset is low and in the cycle after it, `run_valid`=0, `bubble`=1, `flush`=0, `redirect`=0 and `run_tid`=0. All contexts are idle after reset.
- R2: A launch request (`launch_valid` with `launch_tid`, `launch_pc`) moves an idle thread to ready and records `launch_pc` as its resume PC. The request is ignored for a thread that is not idle. When no thread is running, a ready thread takes the pipeline one cycle after it became ready, with `redirect`=1 and `redirect_pc` equal to its saved PC.
- R3: A long stall (`stall_valid`=1 and `stall_long`=1) on the running thread, while another thread is ready, gives `flush`=1, `redirect`=1, a new `run_tid` and `redirect_pc` equal to the successor's saved PC in the next cycle. At most one thread runs at any time.
- R4: A stall with `stall_long`=0 has no effect: the thread number stays the same and `flush` and `redirect` stay 0.
- R5: When a thread leaves the pipeline, `oldest_pc` of that cycle becomes its saved PC. When it runs again, `redirect_pc` equals that value.
- R6: The successor is the ready thread with the lowest index. The thread most recently preempted by the starvation limit is picked only when no other thread is ready. That demotion ends at the next switch that is not a preemption.
- R7: The starvation count is loaded from `starve_limit` on every switch. After `starve_limit`+1 consecutive cycles of a thread owning the pipeline without a long stall, if another thread is ready, the next cycle shows `flush`=1, `redirect`=1 and the successor's number. The preempted thread becomes ready.
- R8: If the limit runs out while no other thread is ready, the thread keeps running with `flush`=0 and `redirect`=0, and the count restarts from `starve_limit`.
- R9: A long stall with no other thread ready gives `flush`=1, `redirect`=0, `run_valid`=0 and `bubble`=1 in the next cycle, with `run_tid` held. Outside a switch `run_tid` does not change.
- R10: A waiting thread becomes ready only on its bit of `resume`. A resume bit for a thread that is not waiting is ignored.
- R11: A long stall in the same cycle as the limit running out is handled as a stall: the outgoing thread waits for its resume and is not demoted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| launch_valid | input | 1 | Launch request for an idle thread |
| launch_tid | input | 2 | Thread to launch |
| launch_pc | input | 32 | Start PC for the launched thread |
| stall_valid | input | 1 | Pipeline reports a stall of the running thread |
| stall_long | input | 1 | 1: long-latency stall, 0: short stall |
| resume | input | 4 | Per-thread miss-complete pulses |
| oldest_pc | input | 32 | PC of the oldest instruction discarded by a switch |
| starve_limit | input | 16 | Starvation limit, sampled at each reload |
| run_tid | output | 2 | Active thread, selects the register-file bank |
| run_valid | output | 1 | A thread owns the pipeline |
| bubble | output | 1 | No thread owns the pipeline; issue bubbles |
| flush | output | 1 | Discard the outgoing thread's in-flight instructions |
| redirect | output | 1 | Restart fetch at `redirect_pc` |
| redirect_pc | output | 32 | Resume PC of the incoming thread |

## Verification
Every output is registered, so a stall, a preemption or a limit reload shows in the cycle after the stimulus cycle. A launch or resume first makes a thread ready and shows as a redirect one cycle later, two cycles after the pulse when the pipeline was empty. The bench drives inputs on the falling edge, steps its reference model once per cycle, and samples a quarter period after the next rising edge. Each comparison is therefore made one register stage after the stimulus. The directed starvation checks count exactly `starve_limit`+1 owning cycles before they expect a flush.

// File: rtl/cgmt_pkg.sv
// Shared types for the coarse-grained thread switch controller.
package cgmt_pkg;
    typedef enum logic [1:0] {
        CTX_IDLE  = 2'd0,
        CTX_READY = 2'd1,
        CTX_RUN   = 2'd2,
        CTX_WAIT  = 2'd3
    } ctx_state_e;
endpackage

// File: rtl/cgmt_ctx.sv
// One hardware context: lifecycle state and saved resume PC.
// Assumes leave_stall / leave_preempt are only meaningful while this
// context is running; they are gated here by the RUN state.
module cgmt_ctx
    import cgmt_pkg::*;
#(
    parameter int PCW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_hit,
    input  logic [PCW-1:0]   launch_pc,
    input  logic             pick_hit,
    input  logic             leave_stall,
    input  logic             leave_preempt,
    input  logic             resume_hit,
    input  logic [PCW-1:0]   oldest_pc,
    output ctx_state_e       state,
    output logic [PCW-1:0]   saved_pc
);

    // Advance the context state and capture the resume PC on entry/exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= CTX_IDLE;
            saved_pc <= '0;
        end else begin
            case (state)
                CTX_IDLE: begin
                    if (launch_hit) begin
                        state    <= CTX_READY;
                        saved_pc <= launch_pc;
                    end
                end
                CTX_READY: begin
                    if (pick_hit) begin
                        state <= CTX_RUN;
                    end
                end
                CTX_RUN: begin
                    if (leave_stall) begin
                        state    <= CTX_WAIT;
                        saved_pc <= oldest_pc;
                    end else if (leave_preempt) begin
                        state    <= CTX_READY;
                        saved_pc <= oldest_pc;
                    end
                end
                CTX_WAIT: begin
                    if (resume_hit) begin
                        state <= CTX_READY;
                    end
                end
                default: state <= CTX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cgmt_pick.sv
// Successor selector: lowest index among ready contexts, skipping the
// demoted context unless it is the only one ready. Purely combinational.
module cgmt_pick #(
    parameter int NTHR = 4,
    parameter int TIDW = 2
) (
    input  logic [NTHR-1:0] ready_vec,
    input  logic [NTHR-1:0] demote_vec,
    output logic            any_ready,
    output logic [TIDW-1:0] pick_idx
);

    logic [NTHR-1:0] cand;

    // Two-tier fixed priority: normal candidates first, demoted as fallback.
    always_comb begin
        cand = ready_vec & ~demote_vec;
        if (cand == '0) begin
            cand = ready_vec;
        end
        any_ready = |ready_vec;
        pick_idx  = '0;
        for (int i = NTHR - 1; i >= 0; i--) begin
            if (cand[i]) begin
                pick_idx = TIDW'(i);
            end
        end
    end

endmodule

// File: rtl/cgmt_timer.sv
// Starvation down-counter. Loads the limit on reload, counts down while
// a thread owns the pipeline, and reports zero as expiry.
module cgmt_timer #(
    parameter int TMRW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reload,
    input  logic [TMRW-1:0] limit,
    input  logic            count_en,
    output logic            expired
);

    logic [TMRW-1:0] cnt_q;

    // Reload has priority; otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload) begin
            cnt_q <= limit;
        end else if (count_en && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/cgmt_switch_ctrl.sv
// Coarse-grained thread switch controller. Owns the choice of which
// context drives the pipeline; switches only on a long stall or on
// starvation-limit expiry. Assumes the pipeline presents oldest_pc in
// the cycle of the stall and acts on flush/redirect the cycle after.
module cgmt_switch_ctrl
    import cgmt_pkg::*;
#(
    parameter int NTHR = 4,
    parameter int PCW  = 32,
    parameter int TMRW = 16,
    localparam int TIDW = $clog2(NTHR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_valid,
    input  logic [TIDW-1:0]  launch_tid,
    input  logic [PCW-1:0]   launch_pc,
    input  logic             stall_valid,
    input  logic             stall_long,
    input  logic [NTHR-1:0]  resume,
    input  logic [PCW-1:0]   oldest_pc,
    input  logic [TMRW-1:0]  starve_limit,
    output logic [TIDW-1:0]  run_tid,
    output logic             run_valid,
    output logic             bubble,
    output logic             flush,
    output logic             redirect,
    output logic [PCW-1:0]   redirect_pc
);

    ctx_state_e       ctx_st  [NTHR];
    logic [PCW-1:0]   ctx_pc  [NTHR];
    logic [NTHR-1:0]  ready_vec;
    logic [NTHR-1:0]  run_vec;
    logic [NTHR-1:0]  launch_hit;
    logic [NTHR-1:0]  pick_hit;
    logic [NTHR-1:0]  demote_q;
    logic             have_next;
    logic [TIDW-1:0]  pick_idx;
    logic             tmr_zero;
    logic             stall_ev;
    logic             expire;
    logic             preempt;
    logic             sel_now;
    logic             tmr_reload;

    // Switch events seen by the running thread this cycle.
    assign stall_ev   = stall_valid && stall_long && run_valid;
    assign expire     = run_valid && tmr_zero && !stall_ev;
    assign preempt    = expire && have_next;
    assign sel_now    = have_next && (stall_ev || expire || !run_valid);
    assign tmr_reload = sel_now || (expire && !have_next);

    // Per-context state machines and request decode.
    for (genvar g = 0; g < NTHR; g++) begin : g_ctx
        assign ready_vec[g]  = (ctx_st[g] == CTX_READY);
        assign run_vec[g]    = (ctx_st[g] == CTX_RUN);
        assign launch_hit[g] = launch_valid && (launch_tid == TIDW'(g));
        assign pick_hit[g]   = sel_now && (pick_idx == TIDW'(g));

        cgmt_ctx #(
            .PCW (PCW)
        ) u_ctx (
            .clk           (clk),
            .rst_n         (rst_n),
            .launch_hit    (launch_hit[g]),
            .launch_pc     (launch_pc),
            .pick_hit      (pick_hit[g]),
            .leave_stall   (stall_ev),
            .leave_preempt (preempt),
            .resume_hit    (resume[g]),
            .oldest_pc     (oldest_pc),
            .state         (ctx_st[g]),
            .saved_pc      (ctx_pc[g])
        );
    end

    cgmt_pick #(
        .NTHR (NTHR),
        .TIDW (TIDW)
    ) u_pick (
        .ready_vec  (ready_vec),
        .demote_vec (demote_q),
        .any_ready  (have_next),
        .pick_idx   (pick_idx)
    );

    cgmt_timer #(
        .TMRW (TMRW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (tmr_reload),
        .limit    (starve_limit),
        .count_en (run_valid),
        .expired  (tmr_zero)
    );

    // Remember the last preempted thread; any other switch clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            demote_q <= '0;
        end else if (preempt) begin
            demote_q <= NTHR'(1) << run_tid;
        end else if (sel_now) begin
            demote_q <= '0;
        end
    end

    // Registered pipeline-facing controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_tid     <= '0;
            run_valid   <= 1'b0;
            flush       <= 1'b0;
            redirect    <= 1'b0;
            redirect_pc <= '0;
        end else begin
            flush    <= stall_ev || preempt;
            redirect <= sel_now;
            if (sel_now) begin
                run_tid     <= pick_idx;
                run_valid   <= 1'b1;
                redirect_pc <= ctx_pc[pick_idx];
            end else if (stall_ev) begin
                run_valid <= 1'b0;
            end
        end
    end

    assign bubble = !run_valid;

endmodule

// File: rtl/cgmt_switch_chk.sv
// Assertion checker for cgmt_switch_ctrl, attached by bind below.
module cgmt_switch_chk #(
    parameter int NTHR = 4,
    parameter int TIDW = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [TIDW-1:0] run_tid,
    input logic            run_valid,
    input logic            flush,
    input logic            redirect,
    input logic [NTHR-1:0] run_vec
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!run_valid && !flush && !redirect));

    assert_single_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(run_vec) <= 1);

    assert_redirect_has_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> run_valid);

    assert_flush_after_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> $past(run_valid));

    assert_stall_empty_bubble_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !redirect) |-> !run_valid);

    assert_tid_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect |-> $stable(run_tid));

    assert_owner_matches_ctx_R9: assert property (@(posedge clk) disable iff (!rst_n)
        run_valid == (|run_vec));

endmodule

bind cgmt_switch_ctrl cgmt_switch_chk #(
    .NTHR (NTHR),
    .TIDW (TIDW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_tid   (run_tid),
    .run_valid (run_valid),
    .flush     (flush),
    .redirect  (redirect),
    .run_vec   (run_vec)
);

// File: tb/sim_cgmt_switch_ctrl.sv
module sim_cgmt_switch_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NTHR = 4;
    localparam int TIDW = 2;
    localparam int PCW  = 32;
    localparam int TMRW = 16;

    logic            clk;
    logic            rst_n;
    logic            launch_valid;
    logic [TIDW-1:0] launch_tid;
    logic [PCW-1:0]  launch_pc;
    logic            stall_valid;
    logic            stall_long;
    logic [NTHR-1:0] resume;
    logic [PCW-1:0]  oldest_pc;
    logic [TMRW-1:0] starve_limit;
    logic [TIDW-1:0] run_tid;
    logic            run_valid;
    logic            bubble;
    logic            flush;
    logic            redirect;
    logic [PCW-1:0]  redirect_pc;

    cgmt_switch_ctrl #(.NTHR(NTHR), .PCW(PCW), .TMRW(TMRW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .launch_valid(launch_valid), .launch_tid(launch_tid), .launch_pc(launch_pc),
        .stall_valid(stall_valid), .stall_long(stall_long), .resume(resume),
        .oldest_pc(oldest_pc), .starve_limit(starve_limit),
        .run_tid(run_tid), .run_valid(run_valid), .bubble(bubble),
        .flush(flush), .redirect(redirect), .redirect_pc(redirect_pc)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: 0 idle, 1 ready, 2 running, 3 waiting.
    int              m_st [NTHR];
    logic [PCW-1:0]  m_pc [NTHR];
    int              m_tid;
    bit              m_valid, m_flush, m_redir;
    logic [PCW-1:0]  m_rpc;
    int              m_tmr;
    logic [NTHR-1:0] m_dem;
    string           m_tag;
    int              checks = 0;
    int              fails  = 0;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int pick_model(input logic [NTHR-1:0] rdy, input logic [NTHR-1:0] dem);
        for (int i = 0; i < NTHR; i++) if (rdy[i] && !dem[i]) return i;
        for (int i = 0; i < NTHR; i++) if (rdy[i]) return i;
        return 0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NTHR; i++) begin m_st[i] = 0; m_pc[i] = '0; end
        m_tid = 0; m_valid = 0; m_flush = 0; m_redir = 0; m_rpc = '0;
        m_tmr = 0; m_dem = '0;
    endtask

    // One clock of the requirement model, using the inputs now driven.
    task automatic model_step();
        logic [NTHR-1:0] rdy;
        logic [PCW-1:0]  pc_old [NTHR];
        bit sev, exp_raw, expv, have, sel, pre;
        int pk;
        for (int i = 0; i < NTHR; i++) begin rdy[i] = (m_st[i] == 1); pc_old[i] = m_pc[i]; end
        sev     = stall_valid && stall_long && m_valid;
        exp_raw = m_valid && (m_tmr == 0);
        expv    = exp_raw && !sev;
        have    = |rdy;
        sel     = have && (sev || expv || !m_valid);
        pre     = expv && have;
        pk      = pick_model(rdy, m_dem);
        if (sev && exp_raw) m_tag = "R11";
        else if (sev && have) m_tag = "R3";
        else if (sev) m_tag = "R9";
        else if (pre) m_tag = "R7";
        else if (expv) m_tag = "R8";
        else if (sel) m_tag = "R2";
        else if (stall_valid) m_tag = "R4";
        else if (resume != '0) m_tag = "R10";
        else m_tag = "R5";
        for (int i = 0; i < NTHR; i++) begin
            case (m_st[i])
                0: if (launch_valid && int'(launch_tid) == i) begin m_st[i] = 1; m_pc[i] = launch_pc; end
                1: if (sel && pk == i) m_st[i] = 2;
                2: if (sev) begin m_st[i] = 3; m_pc[i] = oldest_pc; end
                   else if (pre) begin m_st[i] = 1; m_pc[i] = oldest_pc; end
                default: if (resume[i]) m_st[i] = 1;
            endcase
        end
        if (sel || (expv && !have)) m_tmr = int'(starve_limit);
        else if (m_valid && m_tmr != 0) m_tmr = m_tmr - 1;
        if (pre) m_dem = NTHR'(1) << m_tid;
        else if (sel) m_dem = '0;
        m_flush = sev || pre;
        m_redir = sel;
        if (sel) begin m_rpc = pc_old[pk]; m_tid = pk; m_valid = 1; end
        else if (sev) m_valid = 0;
    endtask

    task automatic compare_all();
        chk(m_tag, "run_valid", 64'(run_valid), 64'(m_valid));
        chk(m_tag, "bubble",    64'(bubble),    64'(!m_valid));
        chk(m_tag, "flush",     64'(flush),     64'(m_flush));
        chk(m_tag, "redirect",  64'(redirect),  64'(m_redir));
        chk(m_tag, "run_tid",   64'(run_tid),   64'(m_tid));
        if (m_redir) chk(m_tag, "redirect_pc", 64'(redirect_pc), 64'(m_rpc));
    endtask

    task automatic step(input bit sv, input bit sl, input bit lv, input int lt,
                        input logic [PCW-1:0] lp, input logic [NTHR-1:0] rs,
                        input logic [PCW-1:0] op);
        @(negedge clk);
        stall_valid = sv; stall_long = sl; launch_valid = lv;
        launch_tid = TIDW'(lt); launch_pc = lp; resume = rs; oldest_pc = op;
        model_step();
        @(posedge clk);
        #(CLK_PERIOD/4);
        compare_all();
    endtask

    task automatic idle(); step(0, 0, 0, 0, '0, '0, '0); endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; launch_valid = 0; launch_tid = '0; launch_pc = '0;
        stall_valid = 0; stall_long = 0; resume = '0; oldest_pc = '0;
        starve_limit = 16'd40;
        model_reset();
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        // R1: reset state
        chk("R1", "run_valid", 64'(run_valid), 64'd0);
        chk("R1", "bubble",    64'(bubble),    64'd1);
        chk("R1", "flush",     64'(flush),     64'd0);
        chk("R1", "redirect",  64'(redirect),  64'd0);
        chk("R1", "run_tid",   64'(run_tid),   64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        step(0, 0, 1, 2, 32'h200, '0, '0);          // launch t2
        idle();
        // R2: empty pipeline picks the launched thread
        chk("R2", "run_tid",     64'(run_tid),     64'd2);
        chk("R2", "redirect_pc", 64'(redirect_pc), 64'h200);
        step(0, 0, 1, 1, 32'h100, '0, '0);          // launch t1
        step(0, 0, 1, 3, 32'h300, '0, '0);          // launch t3
        step(1, 0, 1, 2, 32'h999, '0, '0);          // short stall + launch of running t2
        // R4: short stall ignored
        chk("R4", "run_tid",  64'(run_tid),  64'd2);
        chk("R4", "flush",    64'(flush),    64'd0);
        chk("R4", "redirect", 64'(redirect), 64'd0);
        step(1, 1, 0, 0, '0, '0, 32'h2A0);          // long stall on t2
        // R3 / R6: lowest ready index wins
        chk("R3", "flush",       64'(flush),       64'd1);
        chk("R6", "run_tid",     64'(run_tid),     64'd1);
        chk("R3", "redirect_pc", 64'(redirect_pc), 64'h100);
        step(1, 1, 0, 0, '0, '0, 32'h1B0);          // t1 stalls -> t3
        chk("R3", "run_tid", 64'(run_tid), 64'd3);
        step(1, 1, 0, 0, '0, '0, 32'h3C0);          // t3 stalls, nobody ready
        // R9: bubbles, id held
        chk("R9", "run_valid", 64'(run_valid), 64'd0);
        chk("R9", "redirect",  64'(redirect),  64'd0);
        chk("R9", "run_tid",   64'(run_tid),   64'd3);
        step(0, 0, 0, 0, '0, 4'b0101, '0);          // resume t2, stray resume t0
        chk("R10", "run_valid", 64'(run_valid), 64'd0);
        idle();
        // R10: idle t0 was not woken; R5 + R2: saved PC from the stall, not the ignored launch
        chk("R10", "run_tid",    64'(run_tid),     64'd2);
        chk("R5", "redirect_pc", 64'(redirect_pc), 64'h2A0);
        step(0, 0, 0, 0, '0, 4'b0010, '0);          // resume t1
        starve_limit = 16'd2;
        step(1, 1, 0, 0, '0, '0, 32'h2F0);          // t2 stalls -> t1, limit 2 loaded
        idle(); idle(); idle();                      // third owning cycle expires, none ready
        // R8: limit expiry with nobody ready keeps the owner
        chk("R8", "run_tid",  64'(run_tid),  64'd1);
        chk("R8", "flush",    64'(flush),    64'd0);
        chk("R8", "redirect", 64'(redirect), 64'd0);
        step(0, 0, 0, 0, '0, 4'b1000, '0);          // resume t3
        idle();
        step(0, 0, 0, 0, '0, '0, 32'h1E0);          // expiry with t3 ready
        // R7: preemption after limit+1 owning cycles
        chk("R7", "flush",       64'(flush),       64'd1);
        chk("R7", "run_tid",     64'(run_tid),     64'd3);
        chk("R7", "redirect_pc", 64'(redirect_pc), 64'h3C0);
        step(0, 0, 0, 0, '0, 4'b0100, '0);          // resume t2
        step(1, 1, 0, 0, '0, '0, 32'h3D0);          // t3 stalls; t1 demoted, t2 ready
        // R6: demoted thread loses to t2
        chk("R6", "run_tid",     64'(run_tid),     64'd2);
        chk("R6", "redirect_pc", 64'(redirect_pc), 64'h2F0);
        idle(); idle();
        step(1, 1, 0, 0, '0, '0, 32'h2E0);          // stall in the expiry cycle
        // R11: handled as a stall switch
        chk("R11", "run_tid",     64'(run_tid),     64'd1);
        chk("R11", "redirect_pc", 64'(redirect_pc), 64'h1E0);
        step(1, 1, 0, 0, '0, '0, 32'h1F0);          // t1 stalls; t2 must still be waiting
        chk("R11", "run_valid", 64'(run_valid), 64'd0);
        chk("R11", "redirect",  64'(redirect),  64'd0);

        // Constrained random phase against the model.
        for (int n = 0; n < 3000; n++) begin
            bit sv, sl, lv;
            int lt;
            logic [NTHR-1:0] rs;
            if (($urandom % 50) == 0) starve_limit = TMRW'($urandom % 7);
            sv = (($urandom % 5) == 0);
            sl = ($urandom % 2) == 1;
            lv = (($urandom % 12) == 0);
            lt = int'($urandom % NTHR);
            for (int i = 0; i < NTHR; i++) rs[i] = (($urandom % 6) == 0);
            step(sv, sl, lv, lt, {$urandom} & 32'hFFFF_FFFC, rs,
                 {$urandom} & 32'hFFFF_FFFC);
        end

        summary();
        $finish;
    end

endmodule